// File: doc/BRIEF.md
# Threshold-Triggered Serial FIFO Pair

This block holds the character queues of a serial communication peripheral. A transmit queue takes characters from the processor or DMA side and hands them to the shift-register side. A receive queue runs the other way. Each direction drives an interrupt request and a DMA request. Both requests of a direction come from one programmable fill-level policy, not from plain empty and full flags.

All four data paths use valid/ready handshakes. A producer's character is stored on a clock edge where its valid and the queue's ready are both high. A consumer takes the character on its data port on an edge where valid and its own ready are both high. The producer may hold valid and data while ready is low. Each such cycle is a rejected attempt: it stores nothing and sets the sticky overflow flag. A consumer that raises ready while valid is low sets the sticky underflow flag.

A control input selects queued operation or a single-entry buffer. When that input goes low, both queues are flushed. Requests, ready and valid are combinational functions of the current occupancy, so they follow every accepted transfer on the same clock edge.

Top module: `serial_fifo_pair`

## Requirements
- R1: After reset both queues are empty. tx_in_ready and rx_in_ready are 1, tx_out_valid and rx_out_valid are 0, the transmit requests are 1, the receive requests are 0 and all four error flags are 0.
- R2: With fifo_on=1 each queue holds DEPTH characters (default 16) and returns them in arrival order. Its input ready is 0 exactly while it holds DEPTH characters.
- R3: Transmit code 0 and the reserved code 3 raise the transmit requests whenever the transmit queue holds fewer than DEPTH characters.
- R4: Transmit code 1 raises the transmit requests only while the free space is at least DEPTH/2, that is, while the queue holds at most DEPTH/2 characters.
- R5: Transmit code 2 raises the transmit requests only while the transmit queue is empty.
- R6: Receive code 0 and the reserved code 3 raise the receive requests whenever the receive queue holds at least one character.
- R7: Receive code 1 raises the receive requests only while the receive queue holds at least DEPTH/2 characters.
- R8: Receive code 2 raises the receive requests only while the receive queue holds DEPTH characters.
- R9: In each direction the interrupt request and the DMA request are always equal.
- R10: With fifo_on=0 each path is a one-character buffer. Input ready falls after one character is stored. The threshold codes are ignored: the transmit requests mean the buffer is empty, and the receive requests mean it holds a character.
- R11: When fifo_on changes from 1 to 0, both queues become empty on that clock edge. Handshakes offered in that cycle are not accepted.
- R12: A valid input while its ready is 0 stores nothing and sets the direction's sticky overflow flag on the next edge.
- R13: A consumer ready while its valid is 0 sets the direction's sticky underflow flag on the next edge.
- R14: A one-cycle err_clr pulse clears all four flags on the next edge. A push and a pop accepted in the same cycle leave the occupancy unchanged and keep the order.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| fifo_on | input | 1 | 1 = queued operation, 0 = single-entry buffer; a falling edge flushes |
| tx_level | input | 2 | Transmit request policy code |
| rx_level | input | 2 | Receive request policy code |
| err_clr | input | 1 | Clears the four sticky error flags |
| tx_in_valid | input | 1 | Processor side offers a transmit character |
| tx_in_ready | output | 1 | Transmit queue can accept |
| tx_in_data | input | WIDTH | Transmit character in |
| tx_out_valid | output | 1 | Transmit character available to the shifter |
| tx_out_ready | input | 1 | Shifter takes the transmit character |
| tx_out_data | output | WIDTH | Oldest transmit character |
| rx_in_valid | input | 1 | Shifter offers a received character |
| rx_in_ready | output | 1 | Receive queue can accept |
| rx_in_data | input | WIDTH | Received character in |
| rx_out_valid | output | 1 | Received character available |
| rx_out_ready | input | 1 | Processor side takes the received character |
| rx_out_data | output | WIDTH | Oldest received character |
| tx_irq | output | 1 | Transmit interrupt request |
| tx_dma_req | output | 1 | Transmit DMA request |
| rx_irq | output | 1 | Receive interrupt request |
| rx_dma_req | output | 1 | Receive DMA request |
| tx_ovf | output | 1 | Sticky transmit overflow |
| tx_unf | output | 1 | Sticky transmit underflow |
| rx_ovf | output | 1 | Sticky receive overflow |
| rx_unf | output | 1 | Sticky receive underflow |

## Verification
Occupancy, and with it ready, valid, the head data and all requests, changes on the clock edge that accepts a handshake. The error flags are registered and appear on the edge after the offending cycle. A flush takes effect on the edge after fifo_on falls. A change of a policy code alters the requests with no clock at all. The bench drives inputs on falling edges and reads results on the next falling edge, one rising edge later. It reads the effect of a code change a short delay after the change, with no edge in between.

// File: rtl/sfp_pkg.sv
package sfp_pkg;
  typedef enum logic [1:0] {
    LVL_LOOSE = 2'd0,
    LVL_HALF  = 2'd1,
    LVL_EDGE  = 2'd2,
    LVL_SPARE = 2'd3
  } level_e;
endpackage

// File: rtl/sfp_buffer.sv
module sfp_buffer #(
  parameter int DEPTH = 16,
  parameter int WIDTH = 8,
  localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int CW = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             flush,
  input  logic             single,
  input  logic             err_clr,
  input  logic             in_valid,
  output logic             in_ready,
  input  logic [WIDTH-1:0] in_data,
  output logic             out_valid,
  input  logic             out_ready,
  output logic [WIDTH-1:0] out_data,
  output logic [CW-1:0]    count,
  output logic             ovf,
  output logic             unf
);
  localparam logic [CW-1:0] FULL_CNT = CW'(DEPTH);
  localparam logic [PW-1:0] LAST_PTR = PW'(DEPTH - 1);

  logic [WIDTH-1:0] mem [DEPTH];
  logic [PW-1:0]    wr_ptr, rd_ptr;
  logic             full, push, pop;

  assign full      = single ? (count != '0) : (count == FULL_CNT);
  assign in_ready  = !full && !flush;
  assign out_valid = (count != '0) && !flush;
  assign push      = in_valid && in_ready;
  assign pop       = out_ready && out_valid;
  assign out_data  = mem[rd_ptr];

  function automatic logic [PW-1:0] bump(input logic [PW-1:0] p);
    return (p == LAST_PTR) ? '0 : p + 1'b1;
  endfunction

  always_ff @(posedge clk) begin
    if (push) mem[wr_ptr] <= in_data;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      count  <= '0;
    end else if (flush) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      count  <= '0;
    end else begin
      if (push) wr_ptr <= bump(wr_ptr);
      if (pop)  rd_ptr <= bump(rd_ptr);
      case ({push, pop})
        2'b10:   count <= count + 1'b1;
        2'b01:   count <= count - 1'b1;
        default: count <= count;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ovf <= 1'b0;
      unf <= 1'b0;
    end else begin
      ovf <= (ovf && !err_clr) || (in_valid && !in_ready && !flush);
      unf <= (unf && !err_clr) || (out_ready && !out_valid && !flush);
    end
  end

  // R2: occupancy never exceeds capacity
  a_r2_count_bound: assert property (@(posedge clk) disable iff (!rst_n)
    count <= FULL_CNT);
  // R10: single-entry mode never holds more than one character once settled
  a_r10_single_cap: assert property (@(posedge clk) disable iff (!rst_n)
    single && !flush |-> count <= CW'(1));
  // R11: a flush leaves the queue empty
  a_r11_flush_empties: assert property (@(posedge clk) disable iff (!rst_n)
    flush |=> !out_valid || count == '0);
  // R12: a rejected offer raises overflow
  a_r12_ovf_sets: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && !in_ready && !flush |=> ovf);
  // R13: a pop of an empty queue raises underflow
  a_r13_unf_sets: assert property (@(posedge clk) disable iff (!rst_n)
    out_ready && !out_valid && !flush |=> unf);
  // R14: paired push and pop hold the occupancy
  a_r14_pair_keeps_count: assert property (@(posedge clk) disable iff (!rst_n)
    push && pop |=> $stable(count));
endmodule

// File: rtl/sfp_level_decode.sv
module sfp_level_decode
  import sfp_pkg::*;
#(
  parameter int DEPTH = 16,
  parameter bit IS_TX = 1'b1,
  localparam int CW = $clog2(DEPTH + 1)
) (
  input  logic [CW-1:0] count,
  input  level_e        code,
  input  logic          single,
  output logic          req
);
  localparam logic [CW-1:0] FULL_CNT = CW'(DEPTH);
  localparam logic [CW-1:0] HALF_CNT = CW'(DEPTH / 2);

  logic policy;

  generate
    if (IS_TX) begin : g_tx
      always_comb begin
        unique case (code)
          LVL_HALF: policy = (FULL_CNT - count) >= HALF_CNT;
          LVL_EDGE: policy = (count == '0);
          default:  policy = (count != FULL_CNT);
        endcase
      end
      assign req = single ? (count == '0) : policy;
    end else begin : g_rx
      always_comb begin
        unique case (code)
          LVL_HALF: policy = (count >= HALF_CNT);
          LVL_EDGE: policy = (count == FULL_CNT);
          default:  policy = (count != '0);
        endcase
      end
      assign req = single ? (count != '0) : policy;
    end
  endgenerate
endmodule

// File: rtl/serial_fifo_pair.sv
module serial_fifo_pair
  import sfp_pkg::*;
#(
  parameter int DEPTH = 16,
  parameter int WIDTH = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             fifo_on,
  input  logic [1:0]       tx_level,
  input  logic [1:0]       rx_level,
  input  logic             err_clr,
  input  logic             tx_in_valid,
  output logic             tx_in_ready,
  input  logic [WIDTH-1:0] tx_in_data,
  output logic             tx_out_valid,
  input  logic             tx_out_ready,
  output logic [WIDTH-1:0] tx_out_data,
  input  logic             rx_in_valid,
  output logic             rx_in_ready,
  input  logic [WIDTH-1:0] rx_in_data,
  output logic             rx_out_valid,
  input  logic             rx_out_ready,
  output logic [WIDTH-1:0] rx_out_data,
  output logic             tx_irq,
  output logic             tx_dma_req,
  output logic             rx_irq,
  output logic             rx_dma_req,
  output logic             tx_ovf,
  output logic             tx_unf,
  output logic             rx_ovf,
  output logic             rx_unf
);
  localparam int CW = $clog2(DEPTH + 1);

  logic          on_q, flush, single;
  logic [CW-1:0] tx_cnt, rx_cnt;
  logic          tx_req, rx_req;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) on_q <= 1'b0;
    else        on_q <= fifo_on;
  end

  assign flush  = on_q && !fifo_on;
  assign single = !fifo_on;

  sfp_buffer #(.DEPTH(DEPTH), .WIDTH(WIDTH)) u_tx_buf (
    .clk(clk), .rst_n(rst_n), .flush(flush), .single(single), .err_clr(err_clr),
    .in_valid(tx_in_valid), .in_ready(tx_in_ready), .in_data(tx_in_data),
    .out_valid(tx_out_valid), .out_ready(tx_out_ready), .out_data(tx_out_data),
    .count(tx_cnt), .ovf(tx_ovf), .unf(tx_unf)
  );

  sfp_buffer #(.DEPTH(DEPTH), .WIDTH(WIDTH)) u_rx_buf (
    .clk(clk), .rst_n(rst_n), .flush(flush), .single(single), .err_clr(err_clr),
    .in_valid(rx_in_valid), .in_ready(rx_in_ready), .in_data(rx_in_data),
    .out_valid(rx_out_valid), .out_ready(rx_out_ready), .out_data(rx_out_data),
    .count(rx_cnt), .ovf(rx_ovf), .unf(rx_unf)
  );

  sfp_level_decode #(.DEPTH(DEPTH), .IS_TX(1'b1)) u_tx_lvl (
    .count(tx_cnt), .code(level_e'(tx_level)), .single(single), .req(tx_req)
  );

  sfp_level_decode #(.DEPTH(DEPTH), .IS_TX(1'b0)) u_rx_lvl (
    .count(rx_cnt), .code(level_e'(rx_level)), .single(single), .req(rx_req)
  );

  assign tx_irq     = tx_req;
  assign tx_dma_req = tx_req;
  assign rx_irq     = rx_req;
  assign rx_dma_req = rx_req;

  // R5: empty-only transmit policy never requests while characters wait
  a_r5_tx_empty_only: assert property (@(posedge clk) disable iff (!rst_n)
    fifo_on && tx_level == 2'd2 && tx_irq |-> !tx_out_valid);
  // R8: full-only receive policy requests only when the queue refuses input
  a_r8_rx_full_only: assert property (@(posedge clk) disable iff (!rst_n)
    fifo_on && rx_level == 2'd2 && rx_irq |-> !rx_in_ready);
  // R3: loose transmit policy requests whenever input is accepted
  a_r3_tx_loose: assert property (@(posedge clk) disable iff (!rst_n)
    fifo_on && (tx_level == 2'd0 || tx_level == 2'd3) && tx_in_ready |-> tx_irq);
  // R6: loose receive policy requests whenever a character is available
  a_r6_rx_loose: assert property (@(posedge clk) disable iff (!rst_n)
    fifo_on && (rx_level == 2'd0 || rx_level == 2'd3) && rx_out_valid |-> rx_irq);
endmodule

// File: tb/sim_serial_fifo_pair.sv
module sim_serial_fifo_pair;
  localparam int D = 16;

  logic clk = 1'b0, rst_n = 1'b0;
  logic fifo_on = 1'b0, err_clr = 1'b0;
  logic [1:0] tx_level = 2'd0, rx_level = 2'd0;
  logic tx_in_valid = 1'b0, tx_out_ready = 1'b0, rx_in_valid = 1'b0, rx_out_ready = 1'b0;
  logic [7:0] tx_in_data = '0, rx_in_data = '0;
  logic tx_in_ready, tx_out_valid, rx_in_ready, rx_out_valid;
  logic [7:0] tx_out_data, rx_out_data;
  logic tx_irq, tx_dma_req, rx_irq, rx_dma_req, tx_ovf, tx_unf, rx_ovf, rx_unf;

  int checks = 0, failures = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  serial_fifo_pair u0 (
    .clk(clk), .rst_n(rst_n), .fifo_on(fifo_on), .tx_level(tx_level), .rx_level(rx_level),
    .err_clr(err_clr),
    .tx_in_valid(tx_in_valid), .tx_in_ready(tx_in_ready), .tx_in_data(tx_in_data),
    .tx_out_valid(tx_out_valid), .tx_out_ready(tx_out_ready), .tx_out_data(tx_out_data),
    .rx_in_valid(rx_in_valid), .rx_in_ready(rx_in_ready), .rx_in_data(rx_in_data),
    .rx_out_valid(rx_out_valid), .rx_out_ready(rx_out_ready), .rx_out_data(rx_out_data),
    .tx_irq(tx_irq), .tx_dma_req(tx_dma_req), .rx_irq(rx_irq), .rx_dma_req(rx_dma_req),
    .tx_ovf(tx_ovf), .tx_unf(tx_unf), .rx_ovf(rx_ovf), .rx_unf(rx_unf)
  );

  task automatic check(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic step();
    @(negedge clk);
  endtask

  task automatic tx_push(input logic [7:0] d);
    tx_in_data = d; tx_in_valid = 1'b1; step(); tx_in_valid = 1'b0;
  endtask

  task automatic rx_push(input logic [7:0] d);
    rx_in_data = d; rx_in_valid = 1'b1; step(); rx_in_valid = 1'b0;
  endtask

  task automatic tx_pop(output logic [7:0] d);
    d = tx_out_data; tx_out_ready = 1'b1; step(); tx_out_ready = 1'b0;
  endtask

  task automatic rx_pop(output logic [7:0] d);
    d = rx_out_data; rx_out_ready = 1'b1; step(); rx_out_ready = 1'b0;
  endtask

  task automatic drain_all();
    logic [7:0] d;
    while (tx_out_valid) tx_pop(d);
    while (rx_out_valid) rx_pop(d);
  endtask

  task automatic t_reset();
    check("R1 tx_in_ready", tx_in_ready, 1);
    check("R1 rx_in_ready", rx_in_ready, 1);
    check("R1 tx_out_valid", tx_out_valid, 0);
    check("R1 rx_out_valid", rx_out_valid, 0);
    check("R1 tx_irq", tx_irq, 1);
    check("R1 rx_irq", rx_irq, 0);
    check("R1 flags", {tx_ovf, tx_unf, rx_ovf, rx_unf}, 0);
  endtask

  task automatic t_order();
    logic [7:0] d;
    fifo_on = 1'b1; step();
    for (int i = 0; i < D; i++) tx_push(8'hA0 + 8'(i));
    check("R2 tx full ready", tx_in_ready, 0);
    for (int i = 0; i < D; i++) begin
      tx_pop(d);
      check("R2 tx order", d, 8'hA0 + i);
    end
    check("R2 tx empty after drain", tx_out_valid, 0);
    for (int i = 0; i < D; i++) rx_push(8'h60 + 8'(i));
    check("R2 rx full ready", rx_in_ready, 0);
    for (int i = 0; i < D; i++) begin
      rx_pop(d);
      check("R2 rx order", d, 8'h60 + i);
    end
  endtask

  task automatic t_tx_levels();
    tx_level = 2'd2; #1;
    check("R5 tx code2 empty", tx_irq, 1);
    tx_level = 2'd1; #1;
    check("R4 tx code1 empty", tx_irq, 1);
    step();
    tx_level = 2'd2;
    tx_push(8'h01);
    check("R5 tx code2 one held", tx_irq, 0);
    check("R9 tx dma equal", tx_dma_req, tx_irq);
    for (int i = 1; i < D / 2; i++) tx_push(8'(i));
    tx_level = 2'd1; #1;
    check("R4 tx code1 at half", tx_irq, 1);
    step();
    tx_push(8'h20);
    check("R4 tx code1 past half", tx_irq, 0);
    check("R9 tx dma equal half", tx_dma_req, 0);
    tx_level = 2'd0; #1;
    check("R3 tx code0 not full", tx_irq, 1);
    step();
    while (tx_in_ready) tx_push(8'h33);
    check("R3 tx code0 full", tx_irq, 0);
    tx_level = 2'd3; #1;
    check("R3 tx code3 full", tx_irq, 0);
    step();
    drain_all();
    tx_push(8'h44);
    check("R3 tx code3 not full", tx_irq, 1);
    tx_level = 2'd0;
    drain_all();
  endtask

  task automatic t_rx_levels();
    rx_level = 2'd3; #1;
    check("R6 rx code3 empty", rx_irq, 0);
    step();
    rx_push(8'h01);
    check("R6 rx code3 one", rx_irq, 1);
    rx_level = 2'd0; #1;
    check("R6 rx code0 one", rx_irq, 1);
    check("R9 rx dma equal", rx_dma_req, 1);
    step();
    for (int i = 1; i < D / 2 - 1; i++) rx_push(8'(i));
    rx_level = 2'd1; #1;
    check("R7 rx code1 below half", rx_irq, 0);
    step();
    rx_push(8'h08);
    check("R7 rx code1 at half", rx_irq, 1);
    rx_level = 2'd2; #1;
    check("R8 rx code2 not full", rx_irq, 0);
    step();
    while (rx_in_ready) rx_push(8'h55);
    check("R8 rx code2 full", rx_irq, 1);
    check("R9 rx dma equal full", rx_dma_req, 1);
    rx_level = 2'd0;
    drain_all();
  endtask

  task automatic t_flush();
    for (int i = 0; i < 3; i++) tx_push(8'(i));
    for (int i = 0; i < 2; i++) rx_push(8'(i));
    check("R11 tx holds before", tx_out_valid, 1);
    fifo_on = 1'b0; step();
    check("R11 tx flushed", tx_out_valid, 0);
    check("R11 rx flushed", rx_out_valid, 0);
    check("R11 tx ready after flush", tx_in_ready, 1);
    fifo_on = 1'b1; step();
  endtask

  task automatic t_bypass();
    logic [7:0] d;
    fifo_on = 1'b0; tx_level = 2'd0; rx_level = 2'd2; step();
    check("R10 tx empty request", tx_irq, 1);
    tx_push(8'h9C);
    check("R10 tx ready after one", tx_in_ready, 0);
    check("R10 tx code ignored", tx_irq, 0);
    tx_pop(d);
    check("R10 tx data", d, 8'h9C);
    rx_push(8'h3E);
    check("R10 rx ready after one", rx_in_ready, 0);
    check("R10 rx code ignored", rx_irq, 1);
    rx_pop(d);
    check("R10 rx data", d, 8'h3E);
    rx_level = 2'd0; fifo_on = 1'b1; step();
  endtask

  task automatic t_errors();
    logic [7:0] d;
    int n;
    for (int i = 0; i < D; i++) tx_push(8'h10 + 8'(i));
    tx_push(8'h55);
    check("R12 tx overflow flag", tx_ovf, 1);
    n = 0; d = '0;
    while (tx_out_valid) begin tx_pop(d); n++; end
    check("R12 rejected not stored count", n, D);
    check("R12 rejected not stored last", d, 8'h10 + D - 1);
    check("R12 overflow sticky", tx_ovf, 1);
    check("R13 tx no underflow", tx_unf, 0);
    rx_out_ready = 1'b1; step(); rx_out_ready = 1'b0;
    check("R13 rx underflow flag", rx_unf, 1);
    err_clr = 1'b1; step(); err_clr = 1'b0;
    check("R14 flags cleared", {tx_ovf, tx_unf, rx_ovf, rx_unf}, 0);
  endtask

  task automatic t_pairs();
    logic [7:0] d;
    for (int i = 0; i < 5; i++) tx_push(8'h30 + 8'(i));
    d = tx_out_data;
    tx_in_data = 8'h35; tx_in_valid = 1'b1; tx_out_ready = 1'b1;
    step();
    tx_in_valid = 1'b0; tx_out_ready = 1'b0;
    check("R14 paired pop data", d, 8'h30);
    for (int i = 1; i <= 5; i++) begin
      check("R14 paired occupancy", tx_out_valid, 1);
      tx_pop(d);
      check("R14 paired order", d, 8'h30 + i);
    end
    check("R14 paired drained", tx_out_valid, 0);
  endtask

  initial begin
    repeat (3) step();
    rst_n = 1'b1;
    step();
    t_reset();
    t_order();
    t_tx_levels();
    t_rx_levels();
    t_flush();
    t_bypass();
    t_errors();
    t_pairs();
    if (!done) begin
      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      checks++;
      failures++;
      $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule